// File: doc/BRIEF.md
# Configuration File Section Locator

This block reads a configuration file one byte at a time over a valid/ready input stream. It first checks a fixed 13-byte preamble. It then walks the tagged sections that follow: it skips every section except the bitstream section and forwards only that section's content bytes on a valid/ready output stream. The output marks the final byte, and the decoded payload length is presented together with a one-cycle start pulse.

When the preamble does not match, the block reports a format error. If the first eight bytes instead form the raw-stream marker, it also raises a fallback flag, so that the surrounding logic can switch to handling a raw stream. Four sticky status flags report the outcome: success, format error, fallback marker, and input ended early. They hold until the next start.

The state machine has seven states:

- **IDLE** is the state after reset. It moves to **MAGIC** on `start`.
- **MAGIC** compares the preamble and the raw marker. It moves to **TAG** once all 13 preamble bytes have matched, and to **DONE** on a mismatch, on the raw marker, or on the end of input.
- **TAG** checks the tag byte. It moves to **LEN** on a legal tag and to **DONE** on an illegal tag.
- **LEN** collects the length bytes. After the last length byte it moves as follows:
  - a non-bitstream section goes to **SKIP**, or to **TAG** when its length is zero;
  - the bitstream section goes to **PAYLOAD**, or to **DONE** when its length is zero;
  - an implausible length goes to **DONE**.
- **SKIP** discards content bytes and returns to **TAG** after the last one.
- **PAYLOAD** forwards content bytes and moves to **DONE** after the last one.
- **DONE** ignores input and moves to **MAGIC** on `start`.

Top module: `cfl_locator`

## Requirements
- R1: After reset the block is in IDLE: `in_ready`, `out_valid`, `pay_start` and all four status flags are 0. A `start` pulse in IDLE or DONE clears the status flags and `pay_len` at the next clock edge, and parsing begins with the next byte.
- R2: The first 13 bytes must be 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01 in arrival order. On the first byte that differs (and does not continue the raw marker), `error` is set one cycle after that byte is accepted, and no further byte is accepted.
- R3: If the first eight bytes are FF FF FF FF AA 99 55 66 in arrival order, both `fallback_detected` and `error` are set one cycle after the eighth byte is accepted.
- R4: After the preamble, each section is a tag byte followed by a big-endian length. Tags 0x61 to 0x64 ('a' to 'd') carry a 2-byte length, and tag 0x65 ('e', the bitstream section) carries a 4-byte length. Any other tag byte sets `error`.
- R5: A length above 255 on a section other than 'e' sets `error`. A length of exactly 255 is accepted, and the 'e' length has no such limit.
- R6: A non-'e' section is skipped by discarding exactly its length in content bytes. A zero length is legal, and the next byte is then a tag.
- R7: In PAYLOAD, `in_ready` equals `out_ready`, and `out_valid`/`out_data` pass `in_valid`/`in_data` through. The forwarded bytes are exactly the 'e' content, in order, with no byte lost or repeated under backpressure. No other byte is ever presented on the output.
- R8: `pay_start` is high for exactly one cycle, one cycle after the last byte of the 'e' length is accepted, and `pay_len` then shows the decoded 32-bit length. `pay_len` holds that value until the next start.
- R9: `out_last` is high only with the final payload byte. `ok` is set one cycle after that byte is accepted. A zero-length 'e' section sets `ok` with no output beat.
- R10: If a byte carrying `in_last` is accepted before the payload is complete, and that byte does not itself decide an error or success, then `not_found` is set one cycle later.
- R11: `ok`, `error` and `not_found` are mutually exclusive, and `fallback_detected` implies `error`. While any of these flags is set, `in_ready` is 0.
- R12: A `start` pulse during parsing (MAGIC to PAYLOAD) is ignored, and the parse completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new parse (accepted in IDLE/DONE) |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the final byte of the file |
| in_ready | output | 1 | Block accepts the input byte |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Final payload byte |
| out_ready | input | 1 | Downstream accepts the payload byte |
| pay_start | output | 1 | One-cycle pulse when the payload length is known |
| pay_len | output | 32 | Decoded payload length in bytes |
| ok | output | 1 | Payload forwarded completely (sticky) |
| error | output | 1 | Format error (sticky) |
| fallback_detected | output | 1 | Raw-stream marker seen (sticky) |
| not_found | output | 1 | Input ended before the payload completed (sticky) |

## Verification
The payload path is combinational, so `out_valid`, `out_data` and `out_last` are due in the same cycle as the input byte. The bench reads them a short delay after it drives the inputs on the falling edge. `pay_start` and every status flag are registered and appear one cycle after the deciding byte is accepted. The bench therefore reads them on the next falling edge, before it drives any further byte, and counts accepted bytes from the `in_ready` value seen at that same sampling point. The clearing effect of `start` is likewise checked on the falling edge that follows the pulse.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

    localparam int MAGIC_LEN = 13;
    localparam int RAW_LEN   = 8;
    localparam int IDX_W     = $clog2(MAGIC_LEN + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAGIC,
        ST_TAG,
        ST_LEN,
        ST_SKIP,
        ST_PAYLOAD,
        ST_DONE
    } cfl_state_e;

    // Expected preamble byte at a given position.
    function automatic logic [7:0] magic_byte(input logic [IDX_W-1:0] pos);
        logic [7:0] b;
        case (pos)
            IDX_W'(0):  b = 8'h00;
            IDX_W'(1):  b = 8'h09;
            IDX_W'(10): b = 8'h00;
            IDX_W'(11): b = 8'h00;
            IDX_W'(12): b = 8'h01;
            default:    b = pos[0] ? 8'hF0 : 8'h0F;
        endcase
        return b;
    endfunction

    // Expected raw-marker byte at a given position.
    function automatic logic [7:0] raw_byte(input logic [IDX_W-1:0] pos);
        logic [7:0] b;
        case (pos)
            IDX_W'(4): b = 8'hAA;
            IDX_W'(5): b = 8'h99;
            IDX_W'(6): b = 8'h55;
            IDX_W'(7): b = 8'h66;
            default:   b = 8'hFF;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/cfl_marker_match.sv
module cfl_marker_match
    import cfl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       take,
    input  logic [7:0] data,
    output logic       magic_hit,
    output logic       magic_end,
    output logic       raw_hit,
    output logic       raw_end
);

    logic [IDX_W-1:0] pos_q;
    logic             magic_alive_q;
    logic             raw_alive_q;

    // Both candidates are compared in parallel on each byte.
    always_comb begin
        magic_hit = magic_alive_q && (data == magic_byte(pos_q));
        magic_end = magic_hit && (pos_q == IDX_W'(MAGIC_LEN - 1));
        raw_hit   = raw_alive_q && (pos_q < IDX_W'(RAW_LEN))
                    && (data == raw_byte(pos_q));
        raw_end   = raw_hit && (pos_q == IDX_W'(RAW_LEN - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q         <= '0;
            magic_alive_q <= 1'b1;
            raw_alive_q   <= 1'b1;
        end else if (clr) begin
            pos_q         <= '0;
            magic_alive_q <= 1'b1;
            raw_alive_q   <= 1'b1;
        end else if (take) begin
            pos_q         <= pos_q + IDX_W'(1);
            magic_alive_q <= magic_hit;
            raw_alive_q   <= raw_hit;
        end
    end

endmodule

// File: rtl/cfl_len_shift.sv
module cfl_len_shift #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift,
    input  logic [7:0]       data,
    output logic [LEN_W-1:0] len_next
);

    logic [LEN_W-1:0] acc_q;

    // Big-endian: each new byte enters at the bottom.
    assign len_next = {acc_q[LEN_W-9:0], data};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (shift) begin
            acc_q <= len_next;
        end
    end

endmodule

// File: rtl/cfl_down_cnt.sv
module cfl_down_cnt #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             at_one
);

    logic [LEN_W-1:0] cnt_q;

    assign at_one = (cnt_q == LEN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - LEN_W'(1);
        end
    end

endmodule

// File: rtl/cfl_locator.sv
module cfl_locator
    import cfl_pkg::*;
#(
    parameter int         LEN_W     = 32,
    parameter int         SHORT_MAX = 255,
    parameter logic [7:0] TAG_FIRST = 8'h61,
    parameter logic [7:0] TAG_LONG  = 8'h65
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    input  logic             out_ready,
    output logic             pay_start,
    output logic [LEN_W-1:0] pay_len,
    output logic             ok,
    output logic             error,
    output logic             fallback_detected,
    output logic             not_found
);

    localparam int LIDX_W = 2;
    localparam logic [LIDX_W-1:0] SHORT_LAST = LIDX_W'(1);
    localparam logic [LIDX_W-1:0] LONG_LAST  = LIDX_W'(3);

    cfl_state_e state_q, state_nx;

    logic             take;
    logic             start_acc;
    logic             tag_take;
    logic             tag_legal;
    logic             is_long_q;
    logic [LIDX_W-1:0] lidx_q;
    logic             len_final;
    logic [LEN_W-1:0] len_next;
    logic             cnt_one;
    logic             magic_hit, magic_end, raw_hit, raw_end;

    logic             set_ok, set_err, set_raw, set_nf;
    logic             pay_go, cnt_load, cnt_dec;

    logic             ok_q, err_q, raw_q, nf_q, pay_start_q;
    logic [LEN_W-1:0] pay_len_q;

    assign take      = in_valid && in_ready;
    assign start_acc = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    assign tag_take  = take && (state_q == ST_TAG);
    assign tag_legal = (in_data >= TAG_FIRST) && (in_data <= TAG_LONG);
    assign len_final = (lidx_q == (is_long_q ? LONG_LAST : SHORT_LAST));

    cfl_marker_match i_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_acc),
        .take      (take && (state_q == ST_MAGIC)),
        .data      (in_data),
        .magic_hit (magic_hit),
        .magic_end (magic_end),
        .raw_hit   (raw_hit),
        .raw_end   (raw_end)
    );

    cfl_len_shift #(.LEN_W(LEN_W)) i_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tag_take),
        .shift    (take && (state_q == ST_LEN)),
        .data     (in_data),
        .len_next (len_next)
    );

    cfl_down_cnt #(.LEN_W(LEN_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (len_next),
        .dec      (cnt_dec),
        .at_one   (cnt_one)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Next state and events
    always_comb begin
        state_nx = state_q;
        set_ok   = 1'b0;
        set_err  = 1'b0;
        set_raw  = 1'b0;
        set_nf   = 1'b0;
        pay_go   = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_nx = ST_MAGIC;
            end
            ST_MAGIC: begin
                if (take) begin
                    if (raw_end) begin
                        set_err  = 1'b1;
                        set_raw  = 1'b1;
                        state_nx = ST_DONE;
                    end else if (!magic_hit && !raw_hit) begin
                        set_err  = 1'b1;
                        state_nx = ST_DONE;
                    end else if (in_last) begin
                        set_nf   = 1'b1;
                        state_nx = ST_DONE;
                    end else if (magic_end) begin
                        state_nx = ST_TAG;
                    end
                end
            end
            ST_TAG: begin
                if (take) begin
                    if (!tag_legal) begin
                        set_err  = 1'b1;
                        state_nx = ST_DONE;
                    end else if (in_last) begin
                        set_nf   = 1'b1;
                        state_nx = ST_DONE;
                    end else begin
                        state_nx = ST_LEN;
                    end
                end
            end
            ST_LEN: begin
                if (take) begin
                    if (!len_final) begin
                        if (in_last) begin
                            set_nf   = 1'b1;
                            state_nx = ST_DONE;
                        end
                    end else if (!is_long_q && (len_next > LEN_W'(SHORT_MAX))) begin
                        set_err  = 1'b1;
                        state_nx = ST_DONE;
                    end else if (is_long_q) begin
                        pay_go   = 1'b1;
                        cnt_load = 1'b1;
                        if (len_next == '0) begin
                            set_ok   = 1'b1;
                            state_nx = ST_DONE;
                        end else if (in_last) begin
                            set_nf   = 1'b1;
                            state_nx = ST_DONE;
                        end else begin
                            state_nx = ST_PAYLOAD;
                        end
                    end else begin
                        cnt_load = 1'b1;
                        if (in_last) begin
                            set_nf   = 1'b1;
                            state_nx = ST_DONE;
                        end else if (len_next == '0) begin
                            state_nx = ST_TAG;
                        end else begin
                            state_nx = ST_SKIP;
                        end
                    end
                end
            end
            ST_SKIP: begin
                if (take) begin
                    cnt_dec = 1'b1;
                    if (in_last) begin
                        set_nf   = 1'b1;
                        state_nx = ST_DONE;
                    end else if (cnt_one) begin
                        state_nx = ST_TAG;
                    end
                end
            end
            ST_PAYLOAD: begin
                if (take) begin
                    cnt_dec = 1'b1;
                    if (cnt_one) begin
                        set_ok   = 1'b1;
                        state_nx = ST_DONE;
                    end else if (in_last) begin
                        set_nf   = 1'b1;
                        state_nx = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                if (start) state_nx = ST_MAGIC;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Combinational stream outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        out_data  = in_data;
        unique case (state_q)
            ST_MAGIC, ST_TAG, ST_LEN, ST_SKIP: in_ready = 1'b1;
            ST_PAYLOAD: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_last  = in_valid && cnt_one;
            end
            default: in_ready = 1'b0;
        endcase
    end

    // Section bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_long_q <= 1'b0;
            lidx_q    <= '0;
        end else if (tag_take) begin
            is_long_q <= (in_data == TAG_LONG);
            lidx_q    <= '0;
        end else if (take && (state_q == ST_LEN)) begin
            lidx_q    <= lidx_q + LIDX_W'(1);
        end
    end

    // Status and length registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q        <= 1'b0;
            err_q       <= 1'b0;
            raw_q       <= 1'b0;
            nf_q        <= 1'b0;
            pay_start_q <= 1'b0;
            pay_len_q   <= '0;
        end else begin
            pay_start_q <= pay_go;
            if (start_acc) begin
                ok_q      <= 1'b0;
                err_q     <= 1'b0;
                raw_q     <= 1'b0;
                nf_q      <= 1'b0;
                pay_len_q <= '0;
            end else begin
                if (set_ok)  ok_q  <= 1'b1;
                if (set_err) err_q <= 1'b1;
                if (set_raw) raw_q <= 1'b1;
                if (set_nf)  nf_q  <= 1'b1;
                if (pay_go)  pay_len_q <= len_next;
            end
        end
    end

    assign pay_start         = pay_start_q;
    assign pay_len           = pay_len_q;
    assign ok                = ok_q;
    assign error             = err_q;
    assign fallback_detected = raw_q;
    assign not_found         = nf_q;

endmodule

// File: rtl/cfl_locator_chk.sv
module cfl_locator_chk #(
    parameter int LEN_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_last,
    input logic             pay_start,
    input logic [LEN_W-1:0] pay_len,
    input logic             ok,
    input logic             error,
    input logic             fallback_detected,
    input logic             not_found
);

    // R11
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ok, error, not_found}));

    // R3
    raw_implies_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fallback_detected |-> error);

    // R11
    terminal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok || error || not_found) |-> !in_ready);

    // R8
    pay_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_start |=> !pay_start);

    // R8
    pay_len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> $stable(pay_len));

    // R9
    last_then_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> ok);

    // R7
    no_output_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(ok || error || not_found));

endmodule

bind cfl_locator cfl_locator_chk #(.LEN_W(LEN_W)) i_cfl_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .in_ready          (in_ready),
    .out_valid         (out_valid),
    .out_ready         (out_ready),
    .out_last          (out_last),
    .pay_start         (pay_start),
    .pay_len           (pay_len),
    .ok                (ok),
    .error             (error),
    .fallback_detected (fallback_detected),
    .not_found         (not_found)
);

// File: tb/test_cfl_locator.sv
module test_cfl_locator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_last;
    logic        out_ready = 1'b1;
    logic        pay_start;
    logic [31:0] pay_len;
    logic        ok, error, fallback_detected, not_found;

    cfl_locator i_cfl_locator (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
        .pay_start(pay_start), .pay_len(pay_len),
        .ok(ok), .error(error), .fallback_detected(fallback_detected), .not_found(not_found)
    );

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_errs   = 0;

    logic [7:0] file_q [0:1023];
    int         file_n;
    logic [7:0] rx_d   [0:1023];
    int         rx_n, last_cnt, last_pos, ps_cnt, n_acc;
    logic [31:0] ps_len;

    task automatic chk(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!cond) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pay_pat(input int k);
        return 8'((k * 7 + 3) & 255);
    endfunction

    task automatic put(input logic [7:0] b);
        file_q[file_n] = b;
        file_n++;
    endtask

    task automatic put_magic();
        put(8'h00); put(8'h09);
        for (int k = 0; k < 4; k++) begin put(8'h0F); put(8'hF0); end
        put(8'h00); put(8'h00); put(8'h01);
    endtask

    task automatic put_short(input logic [7:0] tag, input int len);
        put(tag); put(8'(len >> 8)); put(8'(len));
        for (int k = 0; k < len; k++) put(8'h65);
    endtask

    task automatic put_long(input int len);
        put(8'h65);
        put(8'(len >> 24)); put(8'(len >> 16)); put(8'(len >> 8)); put(8'(len));
        for (int k = 0; k < len; k++) put(pay_pat(k));
    endtask

    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic feed(input bit gaps, input bit bp, input bit poke);
        int i = 0;
        int cyc = 0;
        bit acc;
        rx_n = 0; last_cnt = 0; last_pos = -1; ps_cnt = 0; ps_len = 0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (pay_start) begin ps_cnt++; ps_len = pay_len; end
            if (ok || error || not_found || i >= file_n || cyc > 20000) begin
                in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
                break;
            end
            cyc++;
            in_valid  = gaps ? (cyc % 3 != 0) : 1'b1;
            in_data   = file_q[i];
            in_last   = (i == file_n - 1);
            out_ready = bp ? (cyc % 2 == 0) : 1'b1;
            if (poke && cyc == 4) start = 1'b1;
            #1;
            if (out_valid && out_ready) begin
                if (out_last) begin last_cnt++; last_pos = rx_n; end
                rx_d[rx_n] = out_data;
                rx_n++;
            end
            acc = in_valid && in_ready;
            if (acc) i++;
        end
        n_acc = i;
    endtask

    task automatic check_payload(input string req, input int len);
        bit same = 1'b1;
        chk(rx_n == len, req, "payload byte count", rx_n, len);
        for (int k = 0; k < rx_n && k < len; k++)
            if (rx_d[k] != pay_pat(k)) same = 1'b0;
        chk(same, req, "payload content match", same, 1);
    endtask

    task automatic t_reset();
        chk(!in_ready && !out_valid && !pay_start, "R1", "idle outputs", in_ready, 0);
        chk({ok, error, fallback_detected, not_found} == 4'b0, "R1", "idle flags",
            {ok, error, fallback_detected, not_found}, 0);
    endtask

    task automatic t_good(input bit gaps, input bit bp, input bit poke);
        file_n = 0;
        put_magic();
        put_short(8'h61, 3);
        put_short(8'h62, 0);
        put_short(8'h63, 2);
        put_long(5);
        do_start();
        feed(gaps, bp, poke);
        chk(ok && !error && !not_found, poke ? "R12" : "R9", "ok flag", ok, 1);
        check_payload("R7", 5);
        chk(ps_cnt == 1, "R8", "pay_start pulses", ps_cnt, 1);
        chk(ps_len == 32'd5, "R8", "pay_len at pulse", ps_len, 5);
        chk(pay_len == 32'd5, "R8", "pay_len held", pay_len, 5);
        chk(last_cnt == 1 && last_pos == 4, "R9", "out_last position", last_pos, 4);
        chk(n_acc == file_n, "R6", "bytes consumed", n_acc, file_n);
    endtask

    task automatic t_bad_magic();
        file_n = 0;
        put_magic();
        file_q[5] = 8'h11;
        put_long(2);
        do_start();
        chk(!ok && !error && !not_found, "R1", "flags cleared by start", ok, 0);
        feed(1'b0, 1'b0, 1'b0);
        chk(error && !fallback_detected, "R2", "preamble mismatch error", error, 1);
        chk(n_acc == 6, "R2", "bytes accepted before stop", n_acc, 6);
        chk(rx_n == 0, "R7", "no output on error", rx_n, 0);
        repeat (3) @(negedge clk);
        chk(!in_ready, "R11", "in_ready low after error", in_ready, 0);
    endtask

    task automatic t_raw();
        file_n = 0;
        for (int k = 0; k < 4; k++) put(8'hFF);
        put(8'hAA); put(8'h99); put(8'h55); put(8'h66);
        for (int k = 0; k < 8; k++) put(8'h00);
        do_start();
        feed(1'b0, 1'b0, 1'b0);
        chk(fallback_detected && error, "R3", "raw marker", fallback_detected, 1);
        chk(n_acc == 8, "R3", "bytes accepted", n_acc, 8);
    endtask

    task automatic t_raw_near();
        file_n = 0;
        for (int k = 0; k < 4; k++) put(8'hFF);
        put(8'hAA); put(8'h99); put(8'h55); put(8'h67);
        do_start();
        feed(1'b0, 1'b0, 1'b0);
        chk(error && !fallback_detected, "R3", "near-miss raw marker", fallback_detected, 0);
    endtask

    task automatic t_bad_tag();
        file_n = 0;
        put_magic();
        put_short(8'h61, 1);
        put(8'h66); put(8'h00); put(8'h01);
        do_start();
        feed(1'b0, 1'b0, 1'b0);
        chk(error && !ok, "R4", "illegal tag 0x66", error, 1);
        chk(n_acc == 13 + 4 + 1, "R4", "stop at tag", n_acc, 18);
    endtask

    task automatic t_short_big();
        file_n = 0;
        put_magic();
        put(8'h62); put(8'h01); put(8'h00);
        do_start();
        feed(1'b0, 1'b0, 1'b0);
        chk(error && !fallback_detected, "R5", "short length 256", error, 1);
    endtask

    task automatic t_long_payload();
        file_n = 0;
        put_magic();
        put_short(8'h64, 255);
        put_long(256);
        do_start();
        feed(1'b1, 1'b1, 1'b0);
        chk(ok && !error, "R5", "255 skip then 256 payload", ok, 1);
        check_payload("R6", 256);
        chk(ps_len == 32'd256, "R8", "long pay_len", ps_len, 256);
    endtask

    task automatic t_trunc();
        file_n = 0;
        put_magic();
        put_short(8'h61, 4);
        put(8'h62); put(8'h00);
        do_start();
        feed(1'b0, 1'b0, 1'b0);
        chk(not_found && !error && !ok, "R10", "ended inside header", not_found, 1);
        file_n = 0;
        put_magic();
        put_long(6);
        file_n = file_n - 2;
        do_start();
        feed(1'b0, 1'b0, 1'b0);
        chk(not_found && !ok, "R10", "ended inside payload", not_found, 1);
        chk(rx_n == 4 && last_cnt == 0, "R9", "no last on truncated payload", last_cnt, 0);
    endtask

    task automatic t_zero();
        file_n = 0;
        put_magic();
        put_long(0);
        do_start();
        feed(1'b0, 1'b0, 1'b0);
        chk(ok && rx_n == 0, "R9", "zero payload ok, no beats", rx_n, 0);
        chk(ps_cnt == 1 && ps_len == 0, "R8", "zero pay_len pulse", ps_cnt, 1);
    endtask

    initial begin
        bit dog = 1'b0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_good(1'b0, 1'b0, 1'b0);
                t_good(1'b1, 1'b1, 1'b1);
                t_bad_magic();
                t_raw();
                t_raw_near();
                t_bad_tag();
                t_short_big();
                t_long_payload();
                t_trunc();
                t_zero();
            end
            begin
                repeat (150000) @(posedge clk);
                dog = 1'b1;
            end
        join_any
        disable fork;
        if (dog) chk(1'b0, "R1", "watchdog expired", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule